// File: doc/BRIEF.md
# Linear FM Chirp Generator

This block synthesises complex baseband samples of a linear frequency sweep for a transmit DAC. The frequency is held as a signed fraction of the sample rate. A value of 0x80000000 is the negative band edge, so a pulse started there and ramped upward sweeps the whole band from minus half to plus half of the sample rate. Three configuration words set the sweep: a 32-bit start frequency, a 32-bit increment added to the frequency after every sample, and an amplitude.

A pulse runs while the on-phase input is high and the application reset is low. At the start of each pulse the frequency reloads the start value and the phase accumulator clears. For each sample the block takes the current phase, turns it into cosine and sine with an iterative CORDIC rotation, and scales both by the amplitude. It then emits signed 14-bit I and Q values with a one-cycle strobe. Outside a pulse the outputs are zero and the strobe is low.

Top module: `chirp_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, tx_strobe is 0 and tx_i and tx_q are 0.
- R2: From the second cycle after tx_on falls, tx_strobe stays 0 and tx_i and tx_q stay 0 for as long as tx_on stays low.
- R3: From the second cycle after app_reset rises, tx_strobe stays 0 and both outputs stay 0 while app_reset is high, even with tx_on high.
- R4: A pulse is enabled when tx_on is high and app_reset is low. The first strobe of a pulse appears ITER+2 clock cycles after the first rising edge at which the pulse is enabled. Later strobes follow every ITER+1 cycles (17 by default), and each strobe lasts exactly one cycle.
- R5: The first sample of every pulse uses phase 0, so tx_i is round(ampl/2) and tx_q is 0, each within 2 LSB.
- R6: The phase of sample k+1 is the phase of sample k plus the frequency of sample k, modulo 2^32. The frequency of sample k is fstart + k*fincr, modulo 2^32. A phase word p stands for the angle 2*pi*p/2^32.
- R7: For a sample of phase angle t, tx_i is round(ampl*cos(t)/2) and tx_q is round(ampl*sin(t)/2), each within 2 LSB, as signed two's complement values. ampl is unsigned.
- R8: tx_i and tx_q saturate to the range -8191..+8191. The value -8192 never appears.
- R9: A pulse that starts after an earlier pulse has ended, or after an application reset, starts again from phase 0 and frequency fstart. It does not continue from the earlier state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| app_reset | input | 1 | Application reset; high stops the chirp |
| tx_on | input | 1 | Transmit-on phase from the pulse scheduler |
| fstart | input | 32 | Signed start frequency word |
| fincr | input | 32 | Per-sample frequency increment |
| ampl | input | 14 | Unsigned output amplitude |
| tx_strobe | output | 1 | Marks a valid I/Q sample |
| tx_i | output | 14 | Signed in-phase sample |
| tx_q | output | 14 | Signed quadrature sample |

## Verification
The generator is driven with these patterns:
- A full-band sweep from 0x80000000. This exercises phase wrap and all four quadrants of the angle fold.
- Constant tones with a zero increment. These separate errors in the phase accumulator from errors in the frequency ramp.
- A quarter-turn start, whose second sample lands exactly on the quadrant boundary at +90 degrees.
- Seeded random start, increment and amplitude values, which cover general rotation accuracy and scaling.
- Full-scale amplitude at 0 and 180 degrees, which tests the saturation limits.
- Repeated pulses with an application reset in the middle of a pulse. These show whether each pulse restarts from phase 0 or carries stale accumulator state.

// File: rtl/chirp_pkg.sv
// Package: shared constants and the CORDIC arctangent table for the chirp generator.
// Assumes a 32-bit phase word where 2^32 is one full turn.
package chirp_pkg;
    localparam int PH_W     = 32;
    localparam int ATAN_MAX = 24;

    // Arctangent of 2^-i, scaled so that 2^32 is one full turn
    function automatic logic [PH_W-1:0] atan_step(input int unsigned i);
        case (i)
            0:  atan_step = 32'h2000_0000;
            1:  atan_step = 32'h12E4_051E;
            2:  atan_step = 32'h09FB_385B;
            3:  atan_step = 32'h0511_11D4;
            4:  atan_step = 32'h028B_0D43;
            5:  atan_step = 32'h0145_D7E1;
            6:  atan_step = 32'h00A2_F61E;
            7:  atan_step = 32'h0051_7C55;
            8:  atan_step = 32'h0028_BE53;
            9:  atan_step = 32'h0014_5F2F;
            10: atan_step = 32'h000A_2F98;
            11: atan_step = 32'h0005_17CC;
            12: atan_step = 32'h0002_8BE6;
            13: atan_step = 32'h0001_45F3;
            14: atan_step = 32'h0000_A2FA;
            15: atan_step = 32'h0000_517D;
            16: atan_step = 32'h0000_28BE;
            17: atan_step = 32'h0000_145F;
            18: atan_step = 32'h0000_0A30;
            19: atan_step = 32'h0000_0518;
            20: atan_step = 32'h0000_028C;
            21: atan_step = 32'h0000_0146;
            22: atan_step = 32'h0000_00A3;
            default: atan_step = 32'h0000_0051;
        endcase
    endfunction
endpackage

// File: rtl/chirp_nco.sv
// Module: frequency and phase accumulators for the chirp.
// On reload it supplies phase 0 and uses fstart as the frequency. On each step it
// adds the frequency to the phase, then adds the increment to the frequency.
// Both sums wrap modulo 2^32.
module chirp_nco
    import chirp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            step,
    input  logic [PH_W-1:0] fstart,
    input  logic [PH_W-1:0] fincr,
    output logic [PH_W-1:0] phase_now
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] freq_q;
    logic [PH_W-1:0] freq_now;

    // Select the values for this sample: restart values on reload, stored values otherwise
    always_comb begin
        phase_now = reload ? '0 : phase_q;
        freq_now  = reload ? fstart : freq_q;
    end

    // Advance both accumulators once per sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            freq_q  <= '0;
        end else if (step) begin
            phase_q <= phase_now + freq_now;
            freq_q  <= freq_now + fincr;
        end
    end

    // R9
    reload_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && step) |=> (phase_q == $past(fstart)));
endmodule

// File: rtl/chirp_cordic.sv
// Module: iterative CORDIC rotation that turns a phase word into cosine and sine.
// The angle is first folded into [-90, +90) degrees by a half-turn rotation, and the
// outputs are negated to undo it. The block takes one iteration per clock and
// raises done after ITER iterations.
// Assumes ITER <= 24. The outputs are scaled by 2^FRAC.
module chirp_cordic
    import chirp_pkg::*;
#(
    parameter int ITER = 16,
    parameter int FRAC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [PH_W-1:0]        angle,
    output logic                   done,
    output logic signed [FRAC+2:0] cos_o,
    output logic signed [FRAC+2:0] sin_o
);
    localparam int DW    = FRAC + 3;
    localparam int CNT_W = $clog2(ITER + 1);
    localparam logic [63:0] X0_W = ((64'd1 << FRAC) * 64'd607253) / 64'd1000000;
    localparam logic signed [DW-1:0] X0 = DW'(X0_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER);

    logic signed [DW-1:0]   x_q, y_q;
    logic signed [PH_W-1:0] z_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   flip_q;
    logic signed [DW-1:0]   x_sh, y_sh;
    logic [PH_W-1:0]        step_ang;

    // Shifted terms and the table angle for the current iteration
    always_comb begin
        x_sh     = x_q >>> cnt_q;
        y_sh     = y_q >>> cnt_q;
        step_ang = atan_step(32'(cnt_q));
        done     = (cnt_q == LAST);
    end

    // Load the folded angle, or run one rotation step toward zero residual angle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            cnt_q  <= LAST;
            flip_q <= 1'b0;
        end else if (load) begin
            flip_q <= angle[PH_W-1] ^ angle[PH_W-2];
            z_q    <= (angle[PH_W-1] ^ angle[PH_W-2]) ? $signed(angle ^ {1'b1, {(PH_W-1){1'b0}}})
                                                      : $signed(angle);
            x_q    <= X0;
            y_q    <= '0;
            cnt_q  <= '0;
        end else if (!done) begin
            if (!z_q[PH_W-1]) begin
                x_q <= x_q - y_sh;
                y_q <= y_q + x_sh;
                z_q <= z_q - $signed(step_ang);
            end else begin
                x_q <= x_q + y_sh;
                y_q <= y_q - x_sh;
                z_q <= z_q + $signed(step_ang);
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Undo the half-turn fold on the results
    always_comb begin
        cos_o = flip_q ? -x_q : x_q;
        sin_o = flip_q ? -y_q : y_q;
    end

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
    // R4
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
endmodule

// File: rtl/chirp_scale.sv
// Module: multiplies a unit-scaled CORDIC output by the amplitude, divides by 2^(FRAC+1)
// with round-half-up, and saturates to a symmetric signed OUT_W-bit range.
// The module is purely combinational.
module chirp_scale #(
    parameter int FRAC  = 16,
    parameter int AMP_W = 14,
    parameter int OUT_W = 14
) (
    input  logic signed [FRAC+2:0]  val,
    input  logic [AMP_W-1:0]        ampl,
    output logic signed [OUT_W-1:0] res
);
    localparam int DW = FRAC + 3;
    localparam int PW = DW + AMP_W + 1;
    localparam logic signed [PW-1:0] POS_LIM = PW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] NEG_LIM = -POS_LIM;
    localparam logic signed [PW-1:0] HALF    = PW'(64'sd1 <<< FRAC);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    // Scale, round and clamp
    always_comb begin
        prod    = PW'(val) * $signed({1'b0, ampl});
        shifted = (prod + HALF) >>> (FRAC + 1);
        if (shifted > POS_LIM)      res = POS_LIM[OUT_W-1:0];
        else if (shifted < NEG_LIM) res = NEG_LIM[OUT_W-1:0];
        else                        res = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/chirp_gen.sv
// Module: top of the linear FM chirp generator.
// While tx_on is high and app_reset is low, it produces one I/Q sample every ITER+1 clocks.
// A pulse starts from phase 0 and frequency fstart. Outside a pulse the outputs are zero.
// The configuration inputs are assumed stable during a pulse.
module chirp_gen #(
    parameter int ITER  = 16,
    parameter int FRAC  = 16,
    parameter int AMP_W = 14,
    parameter int OUT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    app_reset,
    input  logic                    tx_on,
    input  logic [31:0]             fstart,
    input  logic [31:0]             fincr,
    input  logic [AMP_W-1:0]        ampl,
    output logic                    tx_strobe,
    output logic signed [OUT_W-1:0] tx_i,
    output logic signed [OUT_W-1:0] tx_q
);
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic                    go;
    logic                    active_q;
    logic                    reload;
    logic                    load;
    logic                    done;
    logic [31:0]             angle;
    logic signed [FRAC+2:0]  cos_v, sin_v;
    logic signed [OUT_W-1:0] i_v, q_v;

    // Sequencing: restart on pulse entry, start the next sample when the rotation finishes
    always_comb begin
        go     = tx_on && !app_reset;
        reload = go && !active_q;
        load   = go && (!active_q || done);
    end

    chirp_nco u_nco (
        .clk(clk), .rst_n(rst_n), .reload(reload), .step(load),
        .fstart(fstart), .fincr(fincr), .phase_now(angle)
    );

    chirp_cordic #(.ITER(ITER), .FRAC(FRAC)) u_cordic (
        .clk(clk), .rst_n(rst_n), .load(load), .angle(angle),
        .done(done), .cos_o(cos_v), .sin_o(sin_v)
    );

    chirp_scale #(.FRAC(FRAC), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_scale_i (
        .val(cos_v), .ampl(ampl), .res(i_v)
    );

    chirp_scale #(.FRAC(FRAC), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_scale_q (
        .val(sin_v), .ampl(ampl), .res(q_v)
    );

    // Output register: zero outside a pulse, a new sample with strobe when rotation completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            tx_strobe <= 1'b0;
            tx_i      <= '0;
            tx_q      <= '0;
        end else begin
            active_q <= go;
            if (!go) begin
                tx_strobe <= 1'b0;
                tx_i      <= '0;
                tx_q      <= '0;
            end else if (active_q && done) begin
                tx_strobe <= 1'b1;
                tx_i      <= i_v;
                tx_q      <= q_v;
            end else begin
                tx_strobe <= 1'b0;
            end
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_on) |-> (!tx_strobe && tx_i == '0 && tx_q == '0));
    // R3
    app_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(app_reset) |-> (!tx_strobe && tx_i == '0 && tx_q == '0));
    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_i != MOST_NEG) && (tx_q != MOST_NEG));
endmodule

// File: tb/chirp_gen_bench.sv
module chirp_gen_bench;
    localparam int ITER = 16;
    localparam real PI2 = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        app_reset = 1'b0;
    logic        tx_on = 1'b0;
    logic [31:0] fstart = '0;
    logic [31:0] fincr = '0;
    logic [13:0] ampl = '0;
    logic        tx_strobe;
    logic signed [13:0] tx_i, tx_q;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    chirp_gen u_chirp_gen (
        .clk(clk), .rst_n(rst_n), .app_reset(app_reset), .tx_on(tx_on),
        .fstart(fstart), .fincr(fincr), .ampl(ampl),
        .tx_strobe(tx_strobe), .tx_i(tx_i), .tx_q(tx_q)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input int tol);
        n_chk++;
        if (act > exp + tol || act < exp - tol) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_val(input int a, input logic [31:0] ph, input bit sine);
        real t, r;
        int v;
        t = PI2 * real'(ph) / 4294967296.0;
        r = real'(a) * (sine ? $sin(t) : $cos(t)) / 2.0;
        v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
        if (v > 8191) v = 8191;
        if (v < -8191) v = -8191;
        return v;
    endfunction

    // Run one pulse of nsamp samples and compare timing and values
    task automatic run_pulse(input string tag, input logic [31:0] fs, input logic [31:0] fi,
                             input logic [13:0] am, input int nsamp);
        logic [31:0] ph = '0;
        logic [31:0] fr = fs;
        int cyc = 0;
        int last = 0;
        int got = 0;
        @(negedge clk);
        fstart = fs; fincr = fi; ampl = am;
        app_reset = 1'b0; tx_on = 1'b1;
        repeat (nsamp * (ITER + 1) + 1) begin
            @(negedge clk);
            cyc++;
            if (tx_strobe) begin
                if (got == 0) check({tag, " R4 first latency"}, cyc, ITER + 2, 0);
                else          check({tag, " R4 spacing"}, cyc - last, ITER + 1, 0);
                if (got == 0) begin
                    check({tag, " R5 first I"}, int'(tx_i), expect_val(int'(am), 32'd0, 1'b0), 2);
                    check({tag, " R5 first Q"}, int'(tx_q), 0, 2);
                end else begin
                    check({tag, " R6 R7 I"}, int'(tx_i), expect_val(int'(am), ph, 1'b0), 2);
                    check({tag, " R6 R7 Q"}, int'(tx_q), expect_val(int'(am), ph, 1'b1), 2);
                end
                ph = ph + fr;
                fr = fr + fi;
                got++;
                last = cyc;
            end else if (cyc > 1) begin
                if (cyc - last > ITER + 2 && got > 0) check({tag, " R4 missing strobe"}, 1, 0, 0);
            end
        end
        check({tag, " R4 sample count"}, got, nsamp, 0);
        tx_on = 1'b0;
        @(negedge clk);
        @(negedge clk);
        repeat (30) begin
            if (tx_strobe || tx_i != 0 || tx_q != 0) begin
                check({tag, " R2 idle outputs"}, int'(tx_i) + int'(tx_strobe) + int'(tx_q), 0, 0);
                break;
            end
            @(negedge clk);
        end
        check({tag, " R2 idle strobe"}, int'(tx_strobe), 0, 0);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 strobe in reset", int'(tx_strobe), 0, 0);
        check("R1 I in reset", int'(tx_i), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 Q after reset", int'(tx_q), 0, 0);

        // Full band sweep from the negative edge
        run_pulse("sweep", 32'h8000_0000, 32'h0199_999A, 14'd9946, 20);
        // R9: identical pulse again must restart from phase 0
        run_pulse("R9 restart", 32'h8000_0000, 32'h0199_999A, 14'd9946, 6);
        // Constant tone
        run_pulse("tone", 32'h1000_0000, 32'h0, 14'd8000, 12);
        // Quarter-turn start: second sample lands on +90 degrees
        run_pulse("quarter", 32'h4000_0000, 32'h0, 14'd12000, 4);
        // R8: saturation at 0 and 180 degrees
        run_pulse("R8 sat", 32'h8000_0000, 32'h0, 14'd16383, 4);

        // R3: application reset in the middle of a pulse
        @(negedge clk);
        fstart = 32'h0321_0000; fincr = 32'h0001_0000; ampl = 14'd5000;
        tx_on = 1'b1;
        repeat (3 * (ITER + 1) + 5) @(negedge clk);
        app_reset = 1'b1;
        @(negedge clk);
        @(negedge clk);
        begin
            int seen = 0;
            repeat (40) begin
                if (tx_strobe || tx_i != 0 || tx_q != 0) seen++;
                @(negedge clk);
            end
            check("R3 quiet under app reset", seen, 0, 0);
        end
        tx_on = 1'b0;
        // R9: restart after application reset
        run_pulse("R9 after app reset", 32'h0321_0000, 32'h0001_0000, 14'd5000, 5);

        // Seeded random pulses
        for (int k = 0; k < 6; k++) begin
            run_pulse("random", $urandom(), $urandom(), 14'($urandom()), 8);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule